// File: doc/BRIEF.md
# UART Baud Tick Generator

This block produces the 16x oversampling enable that a UART transmitter and receiver share. It can take its timing from the system clock or from an external serial clock pin, and in each case it either uses that source as it is or passes it through a programmable divider. The divider is a power-of-four prescaler (1, 4, 16 or 64) followed by an 8-bit divisor counter.

The output is a single-cycle enable pulse, synchronous to the system clock, that occurs 16 times per bit period. The external clock pin is brought into the system clock domain through a two-flop synchroniser. A rising-edge detector then turns it into a one-cycle source enable. Whenever the prescaler select or the divisor changes, both counters restart from zero. A new rate therefore starts cleanly and does not finish a count that began under the old setting.

Top module: `baud_tick_gen`

## Requirements
- R1: While rst_n is low, tick16_o is 0. After reset is released with source 01, prescaler 00 and divisor D, the first tick is high after the D-th rising clock edge.
- R2: With source select 00 (internal clock, no divider), tick16_o is high in every cycle.
- R3: With source select 01 (internal clock through the divider), tick16_o pulses once every N*D system cycles, where N is the prescale factor and D is the divisor.
- R4: The prescaler select encodes the factor N as 00 = 1, 01 = 4, 10 = 16 and 11 = 64.
- R5: A divisor value of 0 divides by 256.
- R6: With source select 10 (external clock, no divider), each rising edge on ext_clk_i produces exactly one tick. That tick is high in the third cycle after the pin changes, counted from the first rising clock edge that samples the new level.
- R7: With source select 11 (external clock through the divider), tick16_o pulses once every N*D rising edges of ext_clk_i.
- R8: A change of pre_sel_i or divisor_i clears both counters at the next clock edge. The first tick under the new setting comes N*D edges later.
- R9: In the divided modes, with N*D of 2 or more, every tick is high for exactly one cycle.
- R10: With source select 10, an ext_clk_i that stays high produces no tick after its single rising-edge tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_i | input | 1 | External serial clock pin, asynchronous to clk |
| src_sel_i | input | 2 | Clock source: 00 internal direct, 01 internal divided, 10 external direct, 11 external divided |
| pre_sel_i | input | 2 | Prescale factor select: 1, 4, 16 or 64 |
| divisor_i | input | 8 | Divisor; 0 means 256 |
| tick16_o | output | 1 | One-cycle 16x oversampling enable |

## Verification
A divided tick is registered once after the divider's terminal count, so the first tick after reset or after a configuration change appears N*D edges after the edge that cleared the counters. The bench therefore counts falling edges from the falling edge where it drives the change, and it expects the first tick at count N*D+1. A pin edge passes through two synchroniser flops and the output register, so the bench expects that tick on the third falling edge after it drives the pin. For steady rates the bench measures the distance between two consecutive ticks, so sampling phase does not matter. It also checks that the sample one cycle after each tick is low.

// File: rtl/btg_pkg.sv
// Package: shared encodings for the baud tick generator.
// Assumes a 2-bit source select field whose bit 1 picks the external pin
// and whose bit 0 picks the divided path.
package btg_pkg;

    typedef enum logic [1:0] {
        SRC_INT_DIRECT = 2'b00,
        SRC_INT_DIV    = 2'b01,
        SRC_EXT_DIRECT = 2'b10,
        SRC_EXT_DIV    = 2'b11
    } src_mode_e;

    // True when the mode routes the source through the counters.
    function automatic logic mode_divided(input logic [1:0] m);
        return m[0];
    endfunction

    // True when the mode takes its enable from the external pin.
    function automatic logic mode_external(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/btg_pin_sync.sv
// Module: btg_pin_sync
// Brings an asynchronous pin into the clk domain through a chain of STAGES
// flops, then flags a rising edge of the synchronised level for one cycle.
// Assumes the pin stays at each level for at least two clk cycles.
module btg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // First stage samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= pin_i;
    end

    // Remaining stages shift the level along the chain.
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    // Keeps the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;

    // A rising-edge flag lasts one cycle (R6)
    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/btg_prescaler.sv
// Module: btg_prescaler
// Divides a stream of source enables by 4**sel (1, 4, 16 or 64 with a
// 2-bit select). Emits one enable on the source enable that completes the
// count. A clear forces the count to zero and suppresses that cycle's output.
module btg_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             en_o
);

    localparam int CNT_W = 2 * ((1 << SEL_W) - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last;
    logic             wrap;

    // Terminal count is 4**sel - 1.
    always_comb begin
        span = (CNT_W+1)'(1) << (2 * sel_i);
        last = CNT_W'(span - 1'b1);
    end

    assign wrap = en_i && (cnt_q == last);
    assign en_o = wrap && !clr_i;

    // Counts source enables, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (en_i)       cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    // Count stays within the selected range (R4)
    p_pre_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |-> (cnt_q <= last));
    // A clear restarts the prescaler at zero (R8)
    p_pre_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/btg_divider.sv
// Module: btg_divider
// Counts prescaled enables modulo the divisor (0 means 2**DIV_W) and fires
// on the enable that completes each period. Clear has priority, zeroes the
// count and suppresses that cycle's output.
module btg_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             fire_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;
    logic             wrap;

    // Terminal count; a zero divisor maps to the full range.
    always_comb begin
        if (div_i == '0) last = '1;
        else             last = div_i - 1'b1;
    end

    assign wrap   = en_i && (cnt_q == last);
    assign fire_o = wrap && !clr_i;

    // Counts enables, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) cnt_q <= '0;
        else if (en_i)       cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    // Count stays below the divisor (R3)
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |-> (cnt_q <= last));
    // A clear restarts the divider at zero (R8)
    p_div_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/baud_tick_gen.sv
// Module: baud_tick_gen
// Top of the baud tick generator. Picks the internal clock or the
// synchronised external pin edge as the source enable, optionally passes it
// through prescaler and divider, and registers the result as tick16_o.
// Assumes pre_sel_i and divisor_i are quasi-static. Any change to them
// restarts both counters.
module baud_tick_gen
    import btg_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic [1:0]       src_sel_i,
    input  logic [SEL_W-1:0] pre_sel_i,
    input  logic [DIV_W-1:0] divisor_i,
    output logic             tick16_o
);

    localparam int CFG_W = SEL_W + DIV_W;

    logic [CFG_W-1:0] cfg_q;
    logic             cfg_chg;
    logic             ext_rise;
    logic             src_en;
    logic             pre_en;
    logic             div_fire;
    logic             tick_d;

    // Remembers the rate setting; loads it during reset so no restart follows reset.
    always_ff @(posedge clk) begin
        cfg_q <= {pre_sel_i, divisor_i};
    end

    assign cfg_chg = rst_n && ({pre_sel_i, divisor_i} != cfg_q);

    btg_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_clk_i),
        .rise_o (ext_rise)
    );

    assign src_en = mode_external(src_sel_i) ? ext_rise : 1'b1;

    btg_prescaler #(.SEL_W(SEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cfg_chg),
        .en_i   (src_en),
        .sel_i  (pre_sel_i),
        .en_o   (pre_en)
    );

    btg_divider #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cfg_chg),
        .en_i   (pre_en),
        .div_i  (divisor_i),
        .fire_o (div_fire)
    );

    assign tick_d = mode_divided(src_sel_i) ? div_fire : src_en;

    // Registers the selected enable as the output tick.
    always_ff @(posedge clk) begin
        if (!rst_n) tick16_o <= 1'b0;
        else        tick16_o <= tick_d;
    end

    // Internal direct mode ticks every cycle (R2)
    p_int_direct_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel_i == SRC_INT_DIRECT) |=> tick16_o);
    // External direct mode ticks only on a pin rising edge (R10)
    p_ext_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_sel_i == SRC_EXT_DIRECT) && !ext_rise) |=> !tick16_o);
    // A configuration change yields no tick in divided modes (R8)
    p_chg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_chg && mode_divided(src_sel_i)) |=> !tick16_o);

endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;

    localparam int EXT_HALF = 2;
    localparam int NV = 11;
    // columns: src, pre, divisor, expected period in clk cycles
    localparam int VEC [NV][4] = '{
        '{1, 0,   3,     3},   // R3
        '{1, 1,   5,    20},   // R4 x4
        '{1, 2,   2,    32},   // R4 x16
        '{1, 3,   2,   128},   // R4 x64
        '{1, 0,   0,   256},   // R5
        '{1, 3,   0, 16384},   // R5 with x64
        '{1, 3, 255, 16320},   // largest nonzero divisor
        '{3, 0,   3,    12},   // R7 pin period 4
        '{3, 1,   2,    32},   // R7
        '{3, 2,   1,    64},   // R7
        '{2, 0,   7,     4}    // R6 divisor unused
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_run = 1'b0;
    logic       ext_gen = 1'b0;
    logic       ext_man = 1'b0;
    logic       ext_pin;
    logic [1:0] src_sel = 2'b01;
    logic [1:0] pre_sel = 2'b00;
    logic [7:0] divisor = 8'd4;
    logic       tick;
    int         total = 0;
    int         bad = 0;
    int         cyc = 0;
    int         ext_ph = 0;

    always #4 clk = ~clk;

    assign ext_pin = ext_run ? ext_gen : ext_man;

    baud_tick_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_clk_i (ext_pin),
        .src_sel_i (src_sel),
        .pre_sel_i (pre_sel),
        .divisor_i (divisor),
        .tick16_o  (tick)
    );

    // Free-running external clock, changed on falling edges.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (ext_run) begin
            if (ext_ph == EXT_HALF - 1) begin
                ext_gen <= ~ext_gen;
                ext_ph  <= 0;
            end else begin
                ext_ph <= ext_ph + 1;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        if (cyc > 195000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: cycles=%0d limit=195000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Falling edges until tick is seen high, counting from the current one.
    task automatic count_to_tick(input int limit, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tick && n < limit);
    endtask

    // Waits for a tick, then measures the distance to the next one and the width.
    task automatic measure(output int per, output int width_next);
        int n;
        count_to_tick(40000, n);
        @(negedge clk);
        width_next = tick;
        per = 1;
        while (!tick && per < 40000) begin
            @(negedge clk);
            per++;
        end
    endtask

    initial begin
        int n;
        int per;
        int w;
        int cnt;

        // R1: reset holds the tick low
        repeat (4) @(negedge clk);
        check(tick == 1'b0, "R1 reset low", tick, 0);
        rst_n = 1'b1;
        count_to_tick(100, n);
        check(n == 4, "R1 first tick after reset", n, 4);

        // R2: internal direct ticks every cycle
        src_sel = 2'b00;
        repeat (2) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cnt += tick;
        end
        check(cnt == 6, "R2 always high", cnt, 6);

        // Table walk: R3, R4, R5, R7 periods and R9 pulse width
        for (int v = 0; v < NV; v++) begin
            ext_run = (VEC[v][0] >= 2);
            src_sel = 2'(VEC[v][0]);
            pre_sel = 2'(VEC[v][1]);
            divisor = 8'(VEC[v][2]);
            repeat (3) @(negedge clk);
            measure(per, w);
            check(per == VEC[v][3], $sformatf("R3/R4/R5/R7 period vec%0d", v), per, VEC[v][3]);
            check(w == 0, $sformatf("R9 one-cycle pulse vec%0d", v), w, 0);
        end

        // R6: pin edge latency and single tick; R10 no tick while held high
        ext_run = 1'b0;
        ext_man = 1'b0;
        src_sel = 2'b10;
        repeat (5) @(negedge clk);
        ext_man = 1'b1;
        count_to_tick(20, n);
        check(n == 3, "R6 edge latency", n, 3);
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cnt += tick;
        end
        check(cnt == 0, "R10 held pin no tick", cnt, 0);
        ext_man = 1'b0;
        repeat (4) @(negedge clk);
        check(tick == 1'b0, "R10 falling pin no tick", tick, 0);

        // R8: divisor change restarts the count
        src_sel = 2'b01;
        pre_sel = 2'b00;
        divisor = 8'd10;
        repeat (2) @(negedge clk);
        count_to_tick(100, n);
        repeat (3) @(negedge clk);
        divisor = 8'd5;
        count_to_tick(100, n);
        check(n == 6, "R8 divisor change restart", n, 6);

        // R8: prescaler change restarts both counters
        divisor = 8'd3;
        repeat (2) @(negedge clk);
        count_to_tick(100, n);
        @(negedge clk);
        pre_sel = 2'b01;
        count_to_tick(100, n);
        check(n == 13, "R8 prescaler change restart", n, 13);

        // R8: no tick at the change even if the old count was about to end
        pre_sel = 2'b00;
        divisor = 8'd4;
        repeat (2) @(negedge clk);
        count_to_tick(100, n);
        repeat (2) @(negedge clk);
        divisor = 8'd6;
        count_to_tick(100, n);
        check(n == 7, "R8 no stale tick", n, 7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule